// File: doc/BRIEF.md
# Interleaved Memory Window Router

This block owns one fixed range of host physical memory and spreads the accesses that fall in it across a set of downstream host-bridge ports. A request arrives with an offset relative to the start of the window. The router adds the window base to form the full host physical address. It divides that address by the interleave granularity, and the remainder of that quotient modulo the number of targets picks the target. The request then goes downstream carrying the full address, the chosen target and a port number. The port number comes from a per-target decoder lookup, or is forced to zero when pass-through mode skips the lookup.

The target count may be 3, 6 or 12, so the modulo is a true remainder and not a bit slice. A small bit-serial divider computes it. The upstream port is held off with a valid/ready handshake while the divider runs, and only one request is in flight at a time. A request can fail to find a route: it may fall outside the window, have an illegal size, or be refused by the decoder lookup. Such a request never reaches a downstream port. A read completes with zero data and an error. A write is discarded and completes without error. Window base, size, target count, granularity and pass-through mode are loaded together through a single write strobe. A write that breaks the legality rules is refused and raises a configuration error flag.

Top module: `imw_router`

## Requirements
- R1: A configuration write is accepted, and the error flag cleared on the following cycle, when all three rules hold. The size is non-zero with its low 28 bits zero, so it is a multiple of 256 MiB. The target count is one of 1, 2, 3, 4, 6, 8, 12 or 16. The effective granularity code is in 0..6, where code g means 2^(8+g) bytes.
- R2: A configuration write that breaks any rule of R1 sets the error flag on the following cycle and leaves the previously loaded window, count, granularity and mode unchanged.
- R3: When the granularity-valid input is low during a configuration write, the granularity code is taken as 0 (256-byte interleave), whatever the code input holds.
- R4: A forwarded request carries the host physical address, equal to the window base plus the request offset.
- R5: The forwarded target index equals (host physical address >> (8 + granularity code)) modulo the target count.
- R6: In pass-through mode the decoder lookup strobe is never raised, and the request is forwarded on port 0 even if the lookup would report no route.
- R7: A read whose decoder lookup reports no route is not forwarded and completes with read data 0 and the error bit set.
- R8: A write whose decoder lookup reports no route is not forwarded and completes with the error bit clear.
- R9: A request whose offset is not below the window size, including any request made before a legal configuration, is handled as in R7/R8 without a lookup or forward.
- R10: Access sizes 1 to 8 bytes at any byte alignment are forwarded with size and write data unchanged. Sizes 0 and 9 to 15 are handled as in R7/R8.
- R11: After reset the upstream ready is high and no response or downstream request is pending. From the accepting edge until the response cycle, ready stays low.
- R12: A configuration write made while a request is in flight does not change that request's target index or pass-through handling.
- R13: For a forwarded request, the upstream response carries the downstream response data and error bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_base | input | 48 | Window base address |
| cfg_size | input | 48 | Window size in bytes |
| cfg_ways | input | 5 | Number of interleave targets |
| cfg_gran_vld | input | 1 | Granularity code supplied |
| cfg_gran_enc | input | 3 | Granularity code (2^(8+code) bytes) |
| cfg_passthru | input | 1 | Skip decoder lookup, use port 0 |
| cfg_err | output | 1 | Last configuration write was refused |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Upstream request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 40 | Window-relative byte offset |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Upstream completion pulse |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Completion error |
| lk_req | output | 1 | Decoder lookup strobe |
| lk_hpa | output | 48 | Lookup host physical address |
| lk_tgt | output | 4 | Lookup target index |
| lk_hit | input | 1 | Lookup found a route |
| lk_port | input | 8 | Port number from lookup |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | Downstream write |
| dn_hpa | output | 48 | Full host physical address |
| dn_tgt | output | 4 | Target index |
| dn_port | output | 8 | Downstream port number |
| dn_size | output | 4 | Access size |
| dn_wdata | output | 64 | Write data |
| dn_rsp_valid | input | 1 | Downstream completion |
| dn_rsp_rdata | input | 64 | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error |

## Verification
The hardest case to reach from the ports is a configuration change landing while a request is still in flight. The divider and the snapshot of the request context must keep the old count and mode while the configuration registers already hold the new ones. The bench forks a request alongside a delayed configuration write that lands during the multi-cycle divide. It then checks the forwarded target against the old count. It also checks that the configuration itself changed, using a follow-up request. The route-miss paths need a decoder model that refuses one chosen target index, and offsets are picked so that the interleave lands on that index.

// File: rtl/imw_pkg.sv
package imw_pkg;

  localparam int unsigned GRAN_BASE_SHIFT = 8;
  localparam int unsigned WIN_ALIGN_BITS  = 28;
  localparam int unsigned GRAN_CODE_MAX   = 6;
  localparam int unsigned ACCESS_MAX      = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_LOOK,
    ST_FWD,
    ST_WAIT,
    ST_RESP
  } rt_state_e;

  function automatic logic ways_legal(input logic [4:0] w);
    case (w)
      5'd1, 5'd2, 5'd3, 5'd4, 5'd6, 5'd8, 5'd12, 5'd16: ways_legal = 1'b1;
      default:                                          ways_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/imw_cfg.sv
module imw_cfg
  import imw_pkg::*;
#(
  parameter int unsigned HPA_W  = 48,
  parameter int unsigned WAYS_W = 5,
  parameter int unsigned GENC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [HPA_W-1:0]  cfg_base,
  input  logic [HPA_W-1:0]  cfg_size,
  input  logic [WAYS_W-1:0] cfg_ways,
  input  logic              cfg_gran_vld,
  input  logic [GENC_W-1:0] cfg_gran_enc,
  input  logic              cfg_passthru,
  output logic [HPA_W-1:0]  base_q,
  output logic [HPA_W-1:0]  size_q,
  output logic [WAYS_W-1:0] ways_q,
  output logic [GENC_W-1:0] genc_q,
  output logic              pt_q,
  output logic              err_q
);

  logic [GENC_W-1:0] genc_eff;
  logic              size_ok;
  logic              legal;
  logic [HPA_W-1:0]  base_d;
  logic [HPA_W-1:0]  size_d;
  logic [WAYS_W-1:0] ways_d;
  logic [GENC_W-1:0] genc_d;
  logic              pt_d;
  logic              err_d;

  always_comb begin
    genc_eff = cfg_gran_vld ? cfg_gran_enc : '0;
    size_ok  = (cfg_size[WIN_ALIGN_BITS-1:0] == '0) && (cfg_size != '0);
    legal    = size_ok && ways_legal(cfg_ways) &&
               (genc_eff <= GENC_W'(GRAN_CODE_MAX));
  end

  always_comb begin
    base_d = base_q;
    size_d = size_q;
    ways_d = ways_q;
    genc_d = genc_q;
    pt_d   = pt_q;
    err_d  = err_q;
    if (cfg_we) begin
      err_d = !legal;
      if (legal) begin
        base_d = cfg_base;
        size_d = cfg_size;
        ways_d = cfg_ways;
        genc_d = genc_eff;
        pt_d   = cfg_passthru;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      ways_q <= WAYS_W'(1);
      genc_q <= '0;
      pt_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (cfg_we) begin
      base_q <= base_d;
      size_q <= size_d;
      ways_q <= ways_d;
      genc_q <= genc_d;
      pt_q   <= pt_d;
      err_q  <= err_d;
    end
  end

  p_reject_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !legal |=> err_q && (size_q == $past(size_q)) && (ways_q == $past(ways_q)));

  p_size_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(size_q) |-> (size_q[WIN_ALIGN_BITS-1:0] == '0) && !err_q);

endmodule

// File: rtl/imw_moddiv.sv
module imw_moddiv #(
  parameter int unsigned Q_W   = 40,
  parameter int unsigned D_W   = 5,
  localparam int unsigned R_W  = D_W - 1,
  localparam int unsigned CNT_W = $clog2(Q_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [Q_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           done,
  output logic [R_W-1:0] rem
);

  logic [Q_W-1:0]   sh_q,  sh_d;
  logic [R_W-1:0]   rem_q, rem_d;
  logic [D_W-1:0]   div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic [D_W-1:0]   trial;
  logic [D_W-1:0]   reduced;
  logic             en;

  always_comb begin
    trial   = {rem_q, sh_q[Q_W-1]};
    reduced = (trial >= div_q) ? (trial - div_q) : trial;
  end

  always_comb begin
    sh_d   = sh_q;
    rem_d  = rem_q;
    div_d  = div_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (start) begin
      sh_d  = dividend;
      rem_d = '0;
      div_d = divisor;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      sh_d  = {sh_q[Q_W-2:0], 1'b0};
      rem_d = reduced[R_W-1:0];
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(Q_W - 1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  assign en = start || run_q || done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rem_q  <= '0;
      div_q  <= D_W'(1);
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (en) begin
      sh_q   <= sh_d;
      rem_q  <= rem_d;
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign rem  = rem_q;

  p_rem_below_ways_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ({1'b0, rem_q} < div_q));

  p_done_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(run_q));

endmodule

// File: rtl/imw_route.sv
module imw_route
  import imw_pkg::*;
#(
  parameter int unsigned HPA_W  = 48,
  parameter int unsigned OFF_W  = 40,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned TGT_W  = 4,
  parameter int unsigned WAYS_W = 5,
  parameter int unsigned GENC_W = 3,
  parameter int unsigned SIZE_W = 4,
  localparam int unsigned Q_W   = HPA_W - GRAN_BASE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HPA_W-1:0]  base_q,
  input  logic [HPA_W-1:0]  size_q,
  input  logic [WAYS_W-1:0] ways_q,
  input  logic [GENC_W-1:0] genc_q,
  input  logic              pt_q,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              lk_req,
  output logic [HPA_W-1:0]  lk_hpa,
  output logic [TGT_W-1:0]  lk_tgt,
  input  logic              lk_hit,
  input  logic [PORT_W-1:0] lk_port,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [HPA_W-1:0]  dn_hpa,
  output logic [TGT_W-1:0]  dn_tgt,
  output logic [PORT_W-1:0] dn_port,
  output logic [SIZE_W-1:0] dn_size,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic              dn_rsp_err,
  output logic              div_start,
  output logic [Q_W-1:0]    div_dividend,
  output logic [WAYS_W-1:0] div_divisor,
  input  logic              div_done,
  input  logic [TGT_W-1:0]  div_rem
);

  rt_state_e          st_q, st_d;
  logic [HPA_W-1:0]   hpa_q, hpa_d;
  logic               wr_q, wr_d;
  logic [SIZE_W-1:0]  sz_q, sz_d;
  logic [DATA_W-1:0]  wd_q, wd_d;
  logic [WAYS_W-1:0]  cways_q, cways_d;
  logic               cpt_q, cpt_d;
  logic [TGT_W-1:0]   tgt_q, tgt_d;
  logic [PORT_W-1:0]  port_q, port_d;
  logic [DATA_W-1:0]  rd_q, rd_d;
  logic               err_q, err_d;

  logic [HPA_W-1:0]   hpa_in;
  logic [3:0]         shamt;
  logic               in_win;
  logic               size_ok;
  logic               accept;
  logic               en;

  always_comb begin
    hpa_in  = base_q + {{(HPA_W-OFF_W){1'b0}}, req_off};
    shamt   = 4'(GRAN_BASE_SHIFT) + {1'b0, genc_q};
    in_win  = {{(HPA_W-OFF_W){1'b0}}, req_off} < size_q;
    size_ok = (req_size != '0) && (req_size <= SIZE_W'(ACCESS_MAX));
    accept  = req_valid && (st_q == ST_IDLE);
  end

  assign div_start    = accept && in_win && size_ok;
  assign div_dividend = Q_W'(hpa_in >> shamt);
  assign div_divisor  = ways_q;

  always_comb begin
    st_d    = st_q;
    hpa_d   = hpa_q;
    wr_d    = wr_q;
    sz_d    = sz_q;
    wd_d    = wd_q;
    cways_d = cways_q;
    cpt_d   = cpt_q;
    tgt_d   = tgt_q;
    port_d  = port_q;
    rd_d    = rd_q;
    err_d   = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          hpa_d   = hpa_in;
          wr_d    = req_write;
          sz_d    = req_size;
          wd_d    = req_wdata;
          cways_d = ways_q;
          cpt_d   = pt_q;
          if (in_win && size_ok) begin
            st_d = ST_DIV;
          end else begin
            rd_d  = '0;
            err_d = !req_write;
            st_d  = ST_RESP;
          end
        end
      end
      ST_DIV: begin
        if (div_done) begin
          tgt_d = div_rem;
          st_d  = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (cpt_q) begin
          port_d = '0;
          st_d   = ST_FWD;
        end else if (lk_hit) begin
          port_d = lk_port;
          st_d   = ST_FWD;
        end else begin
          rd_d  = '0;
          err_d = !wr_q;
          st_d  = ST_RESP;
        end
      end
      ST_FWD: begin
        if (dn_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (dn_rsp_valid) begin
          rd_d  = dn_rsp_rdata;
          err_d = dn_rsp_err;
          st_d  = ST_RESP;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign en = (st_q != ST_IDLE) || accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      hpa_q   <= '0;
      wr_q    <= 1'b0;
      sz_q    <= '0;
      wd_q    <= '0;
      cways_q <= WAYS_W'(1);
      cpt_q   <= 1'b0;
      tgt_q   <= '0;
      port_q  <= '0;
      rd_q    <= '0;
      err_q   <= 1'b0;
    end else if (en) begin
      st_q    <= st_d;
      hpa_q   <= hpa_d;
      wr_q    <= wr_d;
      sz_q    <= sz_d;
      wd_q    <= wd_d;
      cways_q <= cways_d;
      cpt_q   <= cpt_d;
      tgt_q   <= tgt_d;
      port_q  <= port_d;
      rd_q    <= rd_d;
      err_q   <= err_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_rdata = rd_q;
  assign rsp_err   = err_q;
  assign lk_req    = (st_q == ST_LOOK) && !cpt_q;
  assign lk_hpa    = hpa_q;
  assign lk_tgt    = tgt_q;
  assign dn_valid  = (st_q == ST_FWD);
  assign dn_write  = wr_q;
  assign dn_hpa    = hpa_q;
  assign dn_tgt    = tgt_q;
  assign dn_port   = port_q;
  assign dn_size   = sz_q;
  assign dn_wdata  = wd_q;

  p_stall_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_dn_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_hpa) && $stable(dn_tgt));

  p_tgt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> ({1'b0, dn_tgt} < cways_q));

  p_pt_port_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && cpt_q |-> (dn_port == '0));

  p_rsp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  p_fwd_legal_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_size != '0) && (dn_size <= SIZE_W'(ACCESS_MAX)));

endmodule

// File: rtl/imw_router.sv
module imw_router
  import imw_pkg::*;
#(
  parameter int unsigned HPA_W    = 48,
  parameter int unsigned OFF_W    = 40,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned MAX_WAYS = 16,
  parameter int unsigned GENC_W   = 3,
  parameter int unsigned SIZE_W   = 4,
  localparam int unsigned TGT_W   = $clog2(MAX_WAYS),
  localparam int unsigned WAYS_W  = TGT_W + 1,
  localparam int unsigned Q_W     = HPA_W - GRAN_BASE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [HPA_W-1:0]  cfg_base,
  input  logic [HPA_W-1:0]  cfg_size,
  input  logic [WAYS_W-1:0] cfg_ways,
  input  logic              cfg_gran_vld,
  input  logic [GENC_W-1:0] cfg_gran_enc,
  input  logic              cfg_passthru,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              lk_req,
  output logic [HPA_W-1:0]  lk_hpa,
  output logic [TGT_W-1:0]  lk_tgt,
  input  logic              lk_hit,
  input  logic [PORT_W-1:0] lk_port,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [HPA_W-1:0]  dn_hpa,
  output logic [TGT_W-1:0]  dn_tgt,
  output logic [PORT_W-1:0] dn_port,
  output logic [SIZE_W-1:0] dn_size,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic              dn_rsp_err
);

  logic [HPA_W-1:0]  base_q;
  logic [HPA_W-1:0]  size_q;
  logic [WAYS_W-1:0] ways_q;
  logic [GENC_W-1:0] genc_q;
  logic              pt_q;
  logic              div_start;
  logic [Q_W-1:0]    div_dividend;
  logic [WAYS_W-1:0] div_divisor;
  logic              div_done;
  logic [TGT_W-1:0]  div_rem;

  imw_cfg #(
    .HPA_W (HPA_W),
    .WAYS_W(WAYS_W),
    .GENC_W(GENC_W)
  ) cfg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_base    (cfg_base),
    .cfg_size    (cfg_size),
    .cfg_ways    (cfg_ways),
    .cfg_gran_vld(cfg_gran_vld),
    .cfg_gran_enc(cfg_gran_enc),
    .cfg_passthru(cfg_passthru),
    .base_q      (base_q),
    .size_q      (size_q),
    .ways_q      (ways_q),
    .genc_q      (genc_q),
    .pt_q        (pt_q),
    .err_q       (cfg_err)
  );

  imw_moddiv #(
    .Q_W(Q_W),
    .D_W(WAYS_W)
  ) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (div_start),
    .dividend(div_dividend),
    .divisor (div_divisor),
    .done    (div_done),
    .rem     (div_rem)
  );

  imw_route #(
    .HPA_W (HPA_W),
    .OFF_W (OFF_W),
    .DATA_W(DATA_W),
    .PORT_W(PORT_W),
    .TGT_W (TGT_W),
    .WAYS_W(WAYS_W),
    .GENC_W(GENC_W),
    .SIZE_W(SIZE_W)
  ) route_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_q      (base_q),
    .size_q      (size_q),
    .ways_q      (ways_q),
    .genc_q      (genc_q),
    .pt_q        (pt_q),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_off     (req_off),
    .req_size    (req_size),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .lk_req      (lk_req),
    .lk_hpa      (lk_hpa),
    .lk_tgt      (lk_tgt),
    .lk_hit      (lk_hit),
    .lk_port     (lk_port),
    .dn_valid    (dn_valid),
    .dn_ready    (dn_ready),
    .dn_write    (dn_write),
    .dn_hpa      (dn_hpa),
    .dn_tgt      (dn_tgt),
    .dn_port     (dn_port),
    .dn_size     (dn_size),
    .dn_wdata    (dn_wdata),
    .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_rdata(dn_rsp_rdata),
    .dn_rsp_err  (dn_rsp_err),
    .div_start   (div_start),
    .div_dividend(div_dividend),
    .div_divisor (div_divisor),
    .div_done    (div_done),
    .div_rem     (div_rem)
  );

  p_lookup_not_in_pt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> !dn_valid);

endmodule

// File: tb/imw_router_tb.sv
module imw_router_tb_top;

  localparam int HPA_W = 48;
  localparam int OFF_W = 40;
  localparam int DW    = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [47:0]   cfg_base;
  logic [47:0]   cfg_size;
  logic [4:0]    cfg_ways;
  logic          cfg_gran_vld;
  logic [2:0]    cfg_gran_enc;
  logic          cfg_passthru;
  logic          cfg_err;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [39:0]   req_off;
  logic [3:0]    req_size;
  logic [63:0]   req_wdata;
  logic          rsp_valid;
  logic [63:0]   rsp_rdata;
  logic          rsp_err;
  logic          lk_req;
  logic [47:0]   lk_hpa;
  logic [3:0]    lk_tgt;
  logic          lk_hit;
  logic [7:0]    lk_port;
  logic          dn_valid;
  logic          dn_ready;
  logic          dn_write;
  logic [47:0]   dn_hpa;
  logic [3:0]    dn_tgt;
  logic [7:0]    dn_port;
  logic [3:0]    dn_size;
  logic [63:0]   dn_wdata;
  logic          dn_rsp_valid;
  logic [63:0]   dn_rsp_rdata;
  logic          dn_rsp_err;

  logic [4:0]    miss_tgt;
  logic          miss_all;

  int checks = 0;
  int errors = 0;
  int dn_cnt = 0;
  int lk_cnt = 0;
  logic [47:0] last_hpa;
  logic [3:0]  last_tgt;
  logic [7:0]  last_port;
  logic [3:0]  last_size;
  logic [63:0] last_wdata;
  logic [63:0] r_rdata;
  logic        r_err;
  logic        r_stall_ok;

  always #5 clk = ~clk;

  imw_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_ways(cfg_ways),
    .cfg_gran_vld(cfg_gran_vld), .cfg_gran_enc(cfg_gran_enc), .cfg_passthru(cfg_passthru),
    .cfg_err(cfg_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_off(req_off),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .lk_req(lk_req), .lk_hpa(lk_hpa), .lk_tgt(lk_tgt), .lk_hit(lk_hit), .lk_port(lk_port),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write), .dn_hpa(dn_hpa),
    .dn_tgt(dn_tgt), .dn_port(dn_port), .dn_size(dn_size), .dn_wdata(dn_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata), .dn_rsp_err(dn_rsp_err)
  );

  assign lk_hit  = !miss_all && ({1'b0, lk_tgt} != miss_tgt);
  assign lk_port = {4'hA, lk_tgt};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // downstream and lookup monitor / responder
  initial begin
    dn_rsp_valid = 1'b0;
    dn_rsp_rdata = '0;
    dn_rsp_err   = 1'b0;
    forever begin
      @(negedge clk);
      dn_rsp_valid = 1'b0;
      if (lk_req) lk_cnt++;
      if (dn_valid) begin
        dn_cnt++;
        last_hpa   = dn_hpa;
        last_tgt   = dn_tgt;
        last_port  = dn_port;
        last_size  = dn_size;
        last_wdata = dn_wdata;
        @(negedge clk);
        dn_rsp_valid = 1'b1;
        dn_rsp_rdata = {16'hD00D, last_hpa};
        dn_rsp_err   = (last_hpa[3:0] == 4'h7);
      end
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic write_cfg(input logic [47:0] base, input logic [47:0] size,
                           input logic [4:0] ways, input bit gvld,
                           input logic [2:0] genc, input bit pt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_base = base; cfg_size = size; cfg_ways = ways;
    cfg_gran_vld = gvld; cfg_gran_enc = genc; cfg_passthru = pt;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_req(input bit wr, input logic [39:0] off, input logic [3:0] sz,
                        input logic [63:0] wd);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_off = off; req_size = sz; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_stall_ok = 1'b1;
    guard = 0;
    while (!rsp_valid && guard < 500) begin
      if (req_ready) r_stall_ok = 1'b0;
      @(negedge clk);
      guard++;
    end
    r_rdata = rsp_rdata;
    r_err   = rsp_err;
    if (guard >= 500) chk(1'b0, "R11", "response timeout", 0, 1);
  endtask

  function automatic logic [3:0] exp_tgt(input logic [47:0] hpa, input int enc, input int ways);
    longint unsigned q;
    q = longint'(hpa) >> (8 + enc);
    return 4'(q % longint'(ways));
  endfunction

  // checks one forwarded read end to end
  task automatic fwd_read(input logic [47:0] base, input logic [39:0] off,
                          input int enc, input int ways, input logic [3:0] sz);
    int n0;
    logic [47:0] h;
    n0 = dn_cnt;
    h  = base + {8'h0, off};
    do_req(1'b0, off, sz, 64'h0);
    chk(dn_cnt == n0 + 1, "R4", "forward count", 64'(dn_cnt - n0), 1);
    chk(last_hpa == h, "R4", "host address", 64'(last_hpa), 64'(h));
    chk(last_tgt == exp_tgt(h, enc, ways), "R5", "target index",
        64'(last_tgt), 64'(exp_tgt(h, enc, ways)));
    chk(last_port == {4'hA, last_tgt}, "R5", "lookup port", 64'(last_port), 64'({4'hA, last_tgt}));
    chk(last_size == sz, "R10", "size", 64'(last_size), 64'(sz));
    chk(r_rdata == {16'hD00D, h} && r_err == (h[3:0] == 4'h7), "R13", "response data",
        r_rdata, {16'hD00D, h});
    chk(r_stall_ok, "R11", "ready low in flight", 64'(r_stall_ok), 1);
  endtask

  localparam logic [47:0] BASE = 48'h1_0000_0000;
  localparam logic [47:0] GIB  = 48'h4000_0000;

  task automatic t_reset;
    chk(req_ready == 1'b1, "R11", "reset ready", 64'(req_ready), 1);
    chk(!rsp_valid && !dn_valid && !cfg_err, "R11", "reset idle outputs",
        64'({rsp_valid, dn_valid, cfg_err}), 0);
  endtask

  task automatic t_unconfigured;
    int n0 = dn_cnt;
    do_req(1'b0, 40'h40, 4'd4, 64'h0);
    chk(r_err && r_rdata == 0, "R9", "read before config", r_rdata, 0);
    chk(dn_cnt == n0, "R9", "no forward before config", 64'(dn_cnt - n0), 0);
  endtask

  task automatic t_cfg_valid;
    write_cfg(BASE, GIB, 5'd3, 1'b0, 3'd5, 1'b0);
    chk(cfg_err == 1'b0, "R1", "legal config accepted", 64'(cfg_err), 0);
  endtask

  task automatic t_ways3;
    // gran_vld low with code 5 on the bus: R3 default 256 B
    fwd_read(BASE, 40'h0, 0, 3, 4'd8);
    fwd_read(BASE, 40'h100, 0, 3, 4'd1);
    fwd_read(BASE, 40'h200, 0, 3, 4'd2);
    fwd_read(BASE, 40'h12347, 0, 3, 4'd5);
    fwd_read(BASE, 40'h3FFF_FF03, 0, 3, 4'd3);
  endtask

  task automatic t_ways12;
    write_cfg(BASE + GIB, 2 * GIB, 5'd12, 1'b1, 3'd2, 1'b0);
    chk(cfg_err == 1'b0, "R1", "twelve-way config", 64'(cfg_err), 0);
    fwd_read(BASE + GIB, 40'h0, 2, 12, 4'd8);
    fwd_read(BASE + GIB, 40'hB400, 2, 12, 4'd8);
    fwd_read(BASE + GIB, 40'h7654_3211, 2, 12, 4'd6);
  endtask

  task automatic t_cfg_invalid;
    write_cfg(BASE, 48'h1000_0100, 5'd4, 1'b0, 3'd0, 1'b0);
    chk(cfg_err == 1'b1, "R2", "unaligned size refused", 64'(cfg_err), 1);
    write_cfg(BASE, GIB, 5'd5, 1'b0, 3'd0, 1'b0);
    chk(cfg_err == 1'b1, "R2", "five ways refused", 64'(cfg_err), 1);
    write_cfg(BASE, GIB, 5'd4, 1'b1, 3'd7, 1'b0);
    chk(cfg_err == 1'b1, "R2", "granularity 7 refused", 64'(cfg_err), 1);
    // previous 12-way, code 2 window still in force
    fwd_read(BASE + GIB, 40'hB400, 2, 12, 4'd8);
  endtask

  task automatic t_window_edge;
    int n0;
    fwd_read(BASE + GIB, 40'h7FFF_FFF8, 2, 12, 4'd8);
    n0 = dn_cnt;
    do_req(1'b0, 40'h8000_0000, 4'd8, 64'h0);
    chk(r_err && r_rdata == 0 && dn_cnt == n0, "R9", "offset at size", r_rdata, 0);
  endtask

  task automatic t_route_miss;
    int n0;
    write_cfg(BASE, GIB, 5'd4, 1'b1, 3'd0, 1'b0);
    miss_tgt = 5'd2;
    n0 = dn_cnt;
    do_req(1'b0, 40'h200, 4'd8, 64'h0);
    chk(r_err == 1'b1 && r_rdata == 0, "R7", "read miss response",
        {r_rdata[62:0], r_err}, 1);
    chk(dn_cnt == n0, "R7", "read miss not forwarded", 64'(dn_cnt - n0), 0);
    do_req(1'b1, 40'h600, 4'd8, 64'hCAFE);
    chk(r_err == 1'b0, "R8", "write miss completes ok", 64'(r_err), 0);
    chk(dn_cnt == n0, "R8", "write miss dropped", 64'(dn_cnt - n0), 0);
    do_req(1'b1, 40'h103, 4'd3, 64'h1122_3344_5566_7788);
    chk(dn_cnt == n0 + 1 && last_wdata == 64'h1122_3344_5566_7788, "R10", "write data kept",
        last_wdata, 64'h1122_3344_5566_7788);
    miss_tgt = 5'h1F;
  endtask

  task automatic t_passthru;
    int n0, l0;
    write_cfg(BASE, GIB, 5'd2, 1'b0, 3'd0, 1'b1);
    miss_all = 1'b1;
    n0 = dn_cnt; l0 = lk_cnt;
    do_req(1'b0, 40'h100, 4'd4, 64'h0);
    chk(dn_cnt == n0 + 1 && last_port == 8'h0, "R6", "pass-through port 0",
        64'(last_port), 0);
    chk(lk_cnt == l0, "R6", "no lookup strobe", 64'(lk_cnt - l0), 0);
    chk(last_tgt == 4'd1, "R6", "pass-through target", 64'(last_tgt), 1);
    miss_all = 1'b0;
  endtask

  task automatic t_bad_size;
    int n0;
    write_cfg(BASE, GIB, 5'd4, 1'b0, 3'd0, 1'b0);
    n0 = dn_cnt;
    do_req(1'b0, 40'h10, 4'd0, 64'h0);
    chk(r_err && r_rdata == 0 && dn_cnt == n0, "R10", "size 0 refused", 64'(dn_cnt - n0), 0);
    do_req(1'b0, 40'h10, 4'd9, 64'h0);
    chk(r_err && dn_cnt == n0, "R10", "size 9 refused", 64'(dn_cnt - n0), 0);
    do_req(1'b1, 40'h10, 4'd15, 64'h5);
    chk(!r_err && dn_cnt == n0, "R10", "size 15 write dropped", 64'(r_err), 0);
  endtask

  task automatic t_cfg_midflight;
    // 4 ways active; config switches to 3 ways while the divide runs
    fork
      do_req(1'b0, 40'h500, 4'd8, 64'h0);
      begin
        repeat (6) @(negedge clk);
        write_cfg(BASE, GIB, 5'd3, 1'b0, 3'd0, 1'b0);
      end
    join
    chk(last_tgt == exp_tgt(BASE + 48'h500, 0, 4), "R12", "in-flight keeps old ways",
        64'(last_tgt), 64'(exp_tgt(BASE + 48'h500, 0, 4)));
    fwd_read(BASE, 40'h500, 0, 3, 4'd8);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_base = '0; cfg_size = '0; cfg_ways = '0;
    cfg_gran_vld = 1'b0; cfg_gran_enc = '0; cfg_passthru = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_off = '0; req_size = '0; req_wdata = '0;
    dn_ready = 1'b1;
    miss_tgt = 5'h1F;
    miss_all = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unconfigured();
    t_cfg_valid();
    t_ways3();
    t_ways12();
    t_cfg_invalid();
    t_window_edge();
    t_route_miss();
    t_passthru();
    t_bad_size();
    t_cfg_midflight();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule